// File: doc/BRIEF.md
# Branch and Call Program Sequencer

This block steps the program counter of a small byte-coded 8-bit controller. Each cycle it presents the program counter on a code-memory address port and reads back one byte. It decodes only the control-flow part of the instruction set: short and long jumps, conditional branches on the accumulator or the carry, a count-down branch on one of eight working registers, and subroutine call and return. Any other opcode byte is taken as a one-byte instruction with no effect.

Short branches add a signed 8-bit displacement to the address that follows the whole branch instruction. Long jumps and calls take a 16-bit target, high byte first. A call saves the address of the next instruction on a small internal byte stack, and a return restores it. The accumulator and carry are inputs from outside. When an instruction completes, the block raises a one-cycle strobe and presents the new program counter, so that a checker can follow the program one instruction at a time.

Top module: `branch_seq`

## Requirements
- R1: Reset sets the program counter to 0x0000, the stack pointer to 0x07 and all eight working registers to 0. No retire strobe is raised until the first instruction completes.
- R2: Any opcode outside the set listed below is one byte long. It completes with the program counter advanced by 1.
- R3: Opcode 0x80 is an unconditional two-byte short jump. The target is the address after its displacement byte plus the sign-extended displacement, so the bytes 0x80 0xFE branch back to themselves.
- R4: Opcode 0x60 branches only when the accumulator is 0x00. Opcode 0x70 branches only when the accumulator is non-zero.
- R5: Opcode 0x40 branches only when carry is 1. Opcode 0x50 branches only when carry is 0. A branch that is not taken goes on at the address two bytes past its opcode.
- R6: Opcode 0x02 is a three-byte absolute jump. Byte 1 is the high half of the target and byte 2 is the low half.
- R7: Opcodes 0xD8 to 0xDF decrement working register n, where n is the low three bits of the opcode. The instruction branches relatively when the result is non-zero. A starting count of 0 gives 256 passes, and no other register changes.
- R8: Opcode 0x12 is a three-byte call with the target high byte first. It pushes the address after itself: the stack pointer is incremented before each write, the low byte is written first, then the high byte.
- R9: Opcode 0x22 pops the high byte and then the low byte of the return address into the program counter. The stack pointer is decremented after each read, and nested calls return in LIFO order.
- R10: Relative target addition wraps modulo 2^16, both forward and backward.
- R11: Every completed instruction raises `retireValid` for exactly one cycle, with `retirePc` equal to the address of the next instruction to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| codeData | input | 8 | Code-memory byte at `codeAddr`, combinational read |
| acc | input | 8 | Accumulator value tested by the zero branches |
| carry | input | 1 | Carry flag tested by the carry branches |
| codeAddr | output | 16 | Code-memory byte address, equal to the program counter |
| retireValid | output | 1 | One-cycle pulse when an instruction completes |
| retirePc | output | 16 | Program counter after the completed instruction |

## Verification
A wrong displacement sum, a wrong taken decision or a wrong stack byte shows up on `retirePc` at the very strobe that ends the faulty instruction. This is at most six cycles after its opcode is fetched. A counter that is off by one shows up on the last pass of a 256-pass loop, as an early or late fall-through. Reversed push or pop order is seen only when the return lands at a byte-swapped address, so the calls use targets whose high and low bytes differ. Nested calls expose a stack pointer that drifts.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  localparam logic [7:0] OP_SJMP  = 8'h80;
  localparam logic [7:0] OP_LJMP  = 8'h02;
  localparam logic [7:0] OP_LCALL = 8'h12;
  localparam logic [7:0] OP_RET   = 8'h22;
  localparam logic [7:0] OP_JZ    = 8'h60;
  localparam logic [7:0] OP_JNZ   = 8'h70;
  localparam logic [7:0] OP_JC    = 8'h40;
  localparam logic [7:0] OP_JNC   = 8'h50;
  localparam logic [4:0] OP_DJNZ_HI = 5'b11011;

  typedef enum logic [2:0] {
    ST_FETCH, ST_REL, ST_AHI, ST_ALO, ST_PLO, ST_PHI, ST_RHI, ST_RLO
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pcInc;
    logic pcRel;
    logic pcAbs;
    logic pcTgt;
    logic latchHi;
    logic latchLo;
    logic regDec;
    logic pushLo;
    logic pushHi;
    logic popHi;
    logic popLo;
  } ctrl_t;

  function automatic logic isDjnz(input logic [7:0] op);
    return op[7:3] == OP_DJNZ_HI;
  endfunction

  function automatic logic isRel(input logic [7:0] op);
    return (op == OP_SJMP) || (op == OP_JZ) || (op == OP_JNZ) ||
           (op == OP_JC) || (op == OP_JNC) || isDjnz(op);
  endfunction

endpackage

// File: rtl/bseq_datapath.sv
module bseq_datapath
  import bseq_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int STACK_DEPTH = 16,
  parameter logic [7:0] SP_INIT = 8'h07,
  localparam int REG_AW = $clog2(NUM_REGS),
  localparam int STK_AW = $clog2(STACK_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [REG_AW-1:0] regSel,
  input  logic [7:0]        codeByte,
  output logic [15:0]       pc,
  output logic [7:0]        sp,
  output logic              decNonZero
);

  logic [7:0]  stk [STACK_DEPTH];
  logic [7:0]  regs [NUM_REGS];
  logic [7:0]  hiQ, loQ;
  logic [7:0]  spUp;
  logic [15:0] relTarget;
  logic [7:0]  stkTop;

  assign spUp       = sp + 8'd1;
  assign stkTop     = stk[sp[STK_AW-1:0]];
  // pc points at the displacement byte; the target is relative to the byte after it
  assign relTarget  = pc + 16'd1 + {{8{codeByte[7]}}, codeByte};
  assign decNonZero = regs[regSel] != 8'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
    end else if (ctrl.pcInc) begin
      pc <= pc + 16'd1;
    end else if (ctrl.pcRel) begin
      pc <= relTarget;
    end else if (ctrl.pcAbs) begin
      pc <= {hiQ, codeByte};
    end else if (ctrl.pcTgt) begin
      pc <= {hiQ, loQ};
    end else if (ctrl.popLo) begin
      pc <= {hiQ, stkTop};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp <= SP_INIT;
    end else if (ctrl.pushLo || ctrl.pushHi) begin
      sp <= spUp;
    end else if (ctrl.popHi || ctrl.popLo) begin
      sp <= sp - 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= '0;
      loQ <= '0;
    end else begin
      if (ctrl.latchHi)     hiQ <= codeByte;
      else if (ctrl.popHi)  hiQ <= stkTop;
      if (ctrl.latchLo)     loQ <= codeByte;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.pushLo)      stk[spUp[STK_AW-1:0]] <= pc[7:0];
    else if (ctrl.pushHi) stk[spUp[STK_AW-1:0]] <= pc[15:8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (ctrl.regDec) begin
      regs[regSel] <= regs[regSel] - 8'd1;
    end
  end

endmodule

// File: rtl/bseq_control.sv
module bseq_control
  import bseq_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int REG_AW = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        codeByte,
  input  logic              accZero,
  input  logic              carry,
  input  logic              decNonZero,
  output ctrl_t             ctrl,
  output logic [REG_AW-1:0] regSel,
  output logic              retire
);

  seqState_t state, stateNxt;
  logic [7:0] opQ;
  logic       doRetire;
  logic       taken;

  assign regSel = opQ[REG_AW-1:0];

  always_comb begin
    unique case (1'b1)
      opQ == OP_JZ:  taken = accZero;
      opQ == OP_JNZ: taken = !accZero;
      opQ == OP_JC:  taken = carry;
      opQ == OP_JNC: taken = !carry;
      isDjnz(opQ):   taken = decNonZero;
      default:       taken = 1'b1;
    endcase
  end

  always_comb begin
    ctrl     = '0;
    stateNxt = state;
    doRetire = 1'b0;
    unique case (state)
      ST_FETCH: begin
        ctrl.pcInc = 1'b1;
        if (isRel(codeByte))                               stateNxt = ST_REL;
        else if (codeByte == OP_LJMP || codeByte == OP_LCALL) stateNxt = ST_AHI;
        else if (codeByte == OP_RET)                       stateNxt = ST_RHI;
        else                                               doRetire = 1'b1;
      end
      ST_REL: begin
        ctrl.pcRel  = taken;
        ctrl.pcInc  = !taken;
        ctrl.regDec = isDjnz(opQ);
        doRetire    = 1'b1;
        stateNxt    = ST_FETCH;
      end
      ST_AHI: begin
        ctrl.latchHi = 1'b1;
        ctrl.pcInc   = 1'b1;
        stateNxt     = ST_ALO;
      end
      ST_ALO: begin
        if (opQ == OP_LJMP) begin
          ctrl.pcAbs = 1'b1;
          doRetire   = 1'b1;
          stateNxt   = ST_FETCH;
        end else begin
          ctrl.latchLo = 1'b1;
          ctrl.pcInc   = 1'b1;
          stateNxt     = ST_PLO;
        end
      end
      ST_PLO: begin
        ctrl.pushLo = 1'b1;
        stateNxt    = ST_PHI;
      end
      ST_PHI: begin
        ctrl.pushHi = 1'b1;
        ctrl.pcTgt  = 1'b1;
        doRetire    = 1'b1;
        stateNxt    = ST_FETCH;
      end
      ST_RHI: begin
        ctrl.popHi = 1'b1;
        stateNxt   = ST_RLO;
      end
      ST_RLO: begin
        ctrl.popLo = 1'b1;
        doRetire   = 1'b1;
        stateNxt   = ST_FETCH;
      end
      default: stateNxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_FETCH;
      opQ    <= '0;
      retire <= 1'b0;
    end else begin
      state  <= stateNxt;
      retire <= doRetire;
      if (state == ST_FETCH) opQ <= codeByte;
    end
  end

endmodule

// File: rtl/branch_seq.sv
module branch_seq
  import bseq_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int STACK_DEPTH = 16,
  parameter logic [7:0] SP_INIT = 8'h07,
  localparam int REG_AW = $clog2(NUM_REGS)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  codeData,
  input  logic [7:0]  acc,
  input  logic        carry,
  output logic [15:0] codeAddr,
  output logic        retireValid,
  output logic [15:0] retirePc
);

  ctrl_t             ctrlBus;
  logic [REG_AW-1:0] regSel;
  logic [15:0]       pcVal;
  logic [7:0]        spVal;
  logic              decNonZero;

  bseq_control #(.NUM_REGS(NUM_REGS)) u_ctl (
    .clk(clk), .rstN(rstN), .codeByte(codeData), .accZero(acc == 8'h00),
    .carry(carry), .decNonZero(decNonZero), .ctrl(ctrlBus), .regSel(regSel),
    .retire(retireValid)
  );

  bseq_datapath #(.NUM_REGS(NUM_REGS), .STACK_DEPTH(STACK_DEPTH), .SP_INIT(SP_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrlBus), .regSel(regSel), .codeByte(codeData),
    .pc(pcVal), .sp(spVal), .decNonZero(decNonZero)
  );

  assign codeAddr = pcVal;
  assign retirePc = pcVal;

endmodule

// File: rtl/branch_seq_chk.sv
module branch_seq_chk
  import bseq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [15:0] codeAddr,
  input logic        retireValid,
  input ctrl_t       ctrl,
  input logic [7:0]  sp
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (codeAddr == 16'h0000 && sp == 8'h07 && !retireValid));

  // R8
  push_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pushLo |=> (ctrl.pushHi && sp == $past(sp) + 8'd1));

  // R8
  call_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pushHi |=> (retireValid && sp == $past(sp) + 8'd1));

  // R9
  pop_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.popHi |=> (ctrl.popLo && sp == $past(sp) - 8'd1));

  // R9
  ret_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.popLo |=> (retireValid && sp == $past(sp) - 8'd1));

  // R3
  rel_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.pcRel || ctrl.pcAbs) |=> retireValid);

  // R11
  fetch_after_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    retireValid |-> !(ctrl.pcRel || ctrl.pcAbs || ctrl.pcTgt || ctrl.popLo || ctrl.popHi ||
                      ctrl.pushLo || ctrl.pushHi || ctrl.latchHi || ctrl.latchLo || ctrl.regDec));

  // R11
  pc_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pcInc |=> codeAddr == $past(codeAddr) + 16'd1);

endmodule

bind branch_seq branch_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .codeAddr(codeAddr), .retireValid(retireValid),
  .ctrl(ctrlBus), .sp(spVal)
);

// File: tb/sim_branch_seq.sv
module sim_branch_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  acc = 8'h00;
  logic        carry = 1'b0;
  logic [15:0] codeAddr;
  logic        retireValid;
  logic [15:0] retirePc;
  logic [7:0]  codeData;
  logic [7:0]  mem [512];

  always #10 clk = ~clk;  // 50 MHz

  // code space aliases every 512 bytes, so 0xFFxx lands in the upper half
  assign codeData = mem[codeAddr[8:0]];

  branch_seq u0 (
    .clk(clk), .rstN(rstN), .codeData(codeData), .acc(acc), .carry(carry),
    .codeAddr(codeAddr), .retireValid(retireValid), .retirePc(retirePc)
  );

  logic [15:0] expQ[$];
  string       tagQ[$];
  int          nChecks = 0;
  int          nFails = 0;
  bit          armed = 1'b0;

  task automatic noteCheck(input bit ok, input string tag, input logic [15:0] act,
                           input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expectPc(input logic [15:0] pcExp, input string tag);
    expQ.push_back(pcExp);
    tagQ.push_back(tag);
  endtask

  task automatic put(input int addr, input logic [7:0] b);
    mem[addr[8:0]] = b;
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (armed && rstN && retireValid) begin
      if (expQ.size() == 0) begin
        noteCheck(1'b0, "R11 unexpected retire", retirePc, 16'hxxxx);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        noteCheck(retirePc === e, t, retirePc, e);
      end
    end
  end

  task automatic runProg(input logic [7:0] accV, input logic cyV);
    int waitCnt;
    @(negedge clk);
    acc   = accV;
    carry = cyV;
    repeat (2) @(negedge clk);
    rstN  = 1'b1;
    // R1: reset state visible before the first edge after release
    noteCheck(codeAddr == 16'h0000, "R1 reset pc", codeAddr, 16'h0000);
    noteCheck(retireValid == 1'b0, "R1 no strobe", {15'd0, retireValid}, 16'h0000);
    armed = 1'b1;
    waitCnt = 0;
    while (expQ.size() != 0 && waitCnt < 3000) begin
      @(posedge clk);
      waitCnt++;
    end
    armed = 1'b0;
    if (expQ.size() != 0) begin
      noteCheck(1'b0, {"watchdog ", tagQ[0]}, 16'(expQ.size()), 16'h0000);
      expQ.delete();
      tagQ.delete();
    end
    rstN = 1'b0;
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;

    // R2 / R3 / R11: filler opcodes, forward and backward short jumps, self loop
    put(0, 8'h00); put(1, 8'hA5);
    put(2, 8'h80); put(3, 8'h03);
    put(7, 8'h80); put(8, 8'hFB);
    put(4, 8'h80); put(5, 8'hFE);
    expectPc(16'h0001, "R2 nop");
    expectPc(16'h0002, "R2 unknown opcode");
    expectPc(16'h0007, "R3 forward");
    expectPc(16'h0004, "R3 backward");
    expectPc(16'h0004, "R3 self loop");
    expectPc(16'h0004, "R11 self loop again");
    runProg(8'h00, 1'b0);

    // R4 / R5 with acc zero, carry clear
    put(0, 8'h60); put(1, 8'h03);
    put(5, 8'h70); put(6, 8'h10);
    put(7, 8'h50); put(8, 8'h02);
    put(11, 8'h40); put(12, 8'h20);
    put(13, 8'h80); put(14, 8'hFE);
    expectPc(16'h0005, "R4 jz taken");
    expectPc(16'h0007, "R4 jnz not taken");
    expectPc(16'h000B, "R5 jnc taken");
    expectPc(16'h000D, "R5 jc not taken");
    expectPc(16'h000D, "R3 loop");
    runProg(8'h00, 1'b0);

    // R4 / R5 / R10 with acc non-zero, carry set, backward wrap
    put(0, 8'h60); put(1, 8'h05);
    put(2, 8'h70); put(3, 8'h02);
    put(6, 8'h50); put(7, 8'h04);
    put(8, 8'h40); put(9, 8'hF0);
    put(16'hFFFA, 8'h80); put(16'hFFFB, 8'hFE);
    expectPc(16'h0002, "R4 jz not taken");
    expectPc(16'h0006, "R4 jnz taken");
    expectPc(16'h0008, "R5 jnc not taken");
    expectPc(16'hFFFA, "R10 backward wrap");
    expectPc(16'hFFFA, "R3 loop high");
    runProg(8'h33, 1'b1);

    // R6 / R10: absolute jump then forward wrap
    put(0, 8'h02); put(1, 8'hFF); put(2, 8'hFC);
    put(16'hFFFE, 8'h80); put(16'hFFFF, 8'h10);
    put(16'h0010, 8'h80); put(16'h0011, 8'hFE);
    expectPc(16'hFFFC, "R6 ljmp");
    expectPc(16'hFFFD, "R2 nop high");
    expectPc(16'hFFFE, "R2 nop high2");
    expectPc(16'h0010, "R10 forward wrap");
    expectPc(16'h0010, "R3 loop");
    runProg(8'h01, 1'b0);

    // R8 / R9: nested calls to targets with distinct high/low bytes
    put(0, 8'h12); put(1, 8'h01); put(2, 8'h40);
    put(3, 8'h80); put(4, 8'hFE);
    put(16'h0140, 8'h12); put(16'h0141, 8'h00); put(16'h0142, 8'h50);
    put(16'h0143, 8'h22);
    put(16'h0050, 8'h22);
    expectPc(16'h0140, "R8 call outer");
    expectPc(16'h0050, "R8 call nested");
    expectPc(16'h0143, "R9 return inner");
    expectPc(16'h0003, "R9 return outer");
    expectPc(16'h0003, "R3 loop");
    runProg(8'h00, 1'b0);

    // R7: zero start gives 256 passes; registers are independent
    put(0, 8'hD9); put(1, 8'hFE);
    put(2, 8'hD9); put(3, 8'h02);
    put(6, 8'hDA); put(7, 8'hFE);
    put(8, 8'h80); put(9, 8'hFE);
    for (int i = 0; i < 255; i++) expectPc(16'h0000, "R7 loop r1");
    expectPc(16'h0002, "R7 r1 falls through");
    expectPc(16'h0006, "R7 r1 wraps to 255");
    for (int i = 0; i < 255; i++) expectPc(16'h0006, "R7 loop r2");
    expectPc(16'h0008, "R7 r2 falls through");
    expectPc(16'h0008, "R3 loop");
    runProg(8'h00, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule